// File: doc/BRIEF.md
# Packet Frame Queue Manager

This block manages packet frames that live in a shared buffer memory on a multiprocessor board. The buffer is split into fixed-size frames. Each frame is addressed by a frame index in the high address bits and a word offset in the low bits. Queues inside the block hold frame indices, never packet data. An empty-frame stack supplies frames for new packets. Each local agent (four processors and one memory agent) has its own input queue. Two transmit queues take turns acting as the send queue and the resend queue.

Local agents use a single command port. One command can allocate a frame, write a one-word packet and route it. Multi-word packets are built with three commands: open, put and close. While such a packet is being built, its frame index sits in a holding register. Agents take frames from their own input queue, read words through a read port and release frames when done.

The bus side has a receive port and a transmit port. On the receive side, the block writes incoming words into a fresh frame and rewrites the board field of the header with the sender's board number. The finished packet goes to a local queue chosen by its opcode. On the transmit side, the block offers the head of the active send queue. The bus reports success or rejection for each transfer. Routing reads only the header word.

Top module: `pktq_manager`

## Requirements
- R1: A packet word has 34 bits. Bit 33 is 1 on every word except the final one, where it is 0. A received packet is delivered to its local queue when its first word with bit 33 = 0 is accepted.
- R2: In the header word, bits 25:21 hold the board number, bits 30:26 the opcode and bits 32:31 the processor index. Bits 20:0 are stored but never decoded.
- R3: A header whose board equals `my_board` is routed locally. Opcode 0 goes to the input queue of the processor named by bits 32:31 (agents 0..3). Any nonzero opcode goes to the memory agent's queue (agent 4).
- R4: A header whose board differs from `my_board` is pushed onto the active send queue. The head of that queue appears on `tx_frame` with `tx_valid` high.
- R5: When `tx_done` is accepted with `tx_nack` low, the head frame returns to the free stack. With `tx_nack` high, the head frame moves to the resend queue.
- R6: When the active send queue is empty and the resend queue is not, the two queues exchange roles on the next clock edge. The earliest rejected frame then appears on `tx_frame`.
- R7: The header of a received packet is stored with bits 25:21 replaced by `rx_board`; all its other words are stored unchanged. The packet is routed by opcode alone, as in R3, whatever its board field.
- R8: Command codes on `cmd_op` are: 1 single send, 2 open, 3 put, 4 close, 5 take, 6 release. A single send pops a free frame, writes `cmd_data` at offset 0, routes it by R3/R4 and reports the frame on `rsp_frame`.
- R9: Open pops a free frame into the holding register, writes the header at offset 0 and reports the frame. Put writes `cmd_data` at `cmd_off` of the held frame. Close routes the held frame using the header stored at open.
- R10: With no free frame, single send, open and the first receive word all see their ready output low, and no frame is granted.
- R11: A command whose local destination queue is full sees `cmd_ready` low. Take on an empty queue also sees `cmd_ready` low.
- R12: Frame indices are conserved. Once all frames are released, exactly NUM_FRAMES distinct frames can be allocated again.
- R13: After reset, every frame is free, every queue is empty and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_board | input | 5 | Number of this board |
| cmd_valid | input | 1 | Local command request |
| cmd_op | input | 3 | Command code (R8) |
| cmd_agent | input | 3 | Agent whose queue a take command reads (0..3 processors, 4 memory) |
| cmd_frame | input | FW | Frame returned by a release command |
| cmd_off | input | OW | Word offset for a put command |
| cmd_data | input | 34 | Word written by single send, open or put |
| cmd_ready | output | 1 | Command accepted on this edge when high together with cmd_valid |
| rsp_frame | output | FW | Frame granted, held or taken by the current command |
| rx_valid | input | 1 | Receive word present |
| rx_first | input | 1 | Receive word is a packet header |
| rx_board | input | 5 | Board number of the sending board |
| rx_data | input | 34 | Receive word |
| rx_ready | output | 1 | Receive word accepted; low on a first word means no free frame |
| tx_valid | output | 1 | A frame waits on the send queue |
| tx_frame | output | FW | Frame at the head of the send queue |
| tx_done | input | 1 | Bus transfer of tx_frame finished |
| tx_nack | input | 1 | Receiver had no free frame |
| rd_frame | input | FW | Read port frame index |
| rd_off | input | OW | Read port word offset |
| rd_data | output | 34 | Word stored at rd_frame, rd_off |

## Verification
A frame index lost or duplicated inside the stack or a queue shows up only when the pool is drained. The final allocation sweep then returns fewer than NUM_FRAMES grants, or the same index twice. A wrong role bit after a rejection shows within two cycles: `tx_frame` names a frame other than the rejected one, or `tx_valid` stays low while a frame waits. A misdecoded header field shows up on the very next take command, because the frame appears in the wrong agent's queue. A missed board rewrite shows up on the first read of the received header.

// File: rtl/pktq_pkg.sv
package pktq_pkg;
  localparam int WORD_W    = 34;
  localparam int CONT_BIT  = 33;
  localparam int NUM_PE    = 4;
  localparam int NUM_LOCAL = NUM_PE + 1;
  localparam logic [2:0] DEST_MEM    = 3'd4;
  localparam logic [2:0] DEST_REMOTE = 3'd5;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_SEND1   = 3'd1,
    CMD_OPEN    = 3'd2,
    CMD_PUT     = 3'd3,
    CMD_CLOSE   = 3'd4,
    CMD_TAKE    = 3'd5,
    CMD_RELEASE = 3'd6
  } cmd_e;

  // Destination of a header: 0..3 processor, 4 memory agent, 5 remote.
  function automatic logic [2:0] dest_of(input logic [WORD_W-1:0] hdr,
                                         input logic [4:0] here,
                                         input logic local_only);
    logic [2:0] d;
    if (!local_only && (hdr[25:21] != here)) d = DEST_REMOTE;
    else if (hdr[30:26] == 5'd0)             d = {1'b0, hdr[32:31]};
    else                                     d = DEST_MEM;
    return d;
  endfunction
endpackage

// File: rtl/frame_fifo.sv
module frame_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign head    = slot_q[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= pdata;
  end
endmodule

// File: rtl/frame_stack.sv
module frame_stack #(
  parameter int W     = 3,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  ent_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign top    = empty ? '0 : ent_q[cnt_q - 1'b1];
  assign do_pop = pop && !empty;

  always_comb begin
    cnt_d = cnt_q;
    if (do_pop && !push)  cnt_d = cnt_q - 1'b1;
    if (push && !do_pop)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(DEPTH);
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= W'(i);
    end else begin
      cnt_q <= cnt_d;
      if (push && do_pop)      ent_q[cnt_q - 1'b1] <= pdata;
      else if (push && !full)  ent_q[cnt_q]        <= pdata;
    end
  end
endmodule

// File: rtl/pkt_buffer.sv
module pkt_buffer #(
  parameter int FW = 3,
  parameter int OW = 4,
  parameter int DW = 34
) (
  input  logic             clk,
  input  logic             we,
  input  logic [FW+OW-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [FW+OW-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << (FW + OW);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/pktq_manager.sv
module pktq_manager #(
  parameter int NUM_FRAMES = 8,
  parameter int WORDS      = 16,
  parameter int QDEPTH     = 4,
  localparam int FW = $clog2(NUM_FRAMES),
  localparam int OW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    my_board,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [2:0]    cmd_agent,
  input  logic [FW-1:0] cmd_frame,
  input  logic [OW-1:0] cmd_off,
  input  logic [33:0]   cmd_data,
  output logic          cmd_ready,
  output logic [FW-1:0] rsp_frame,
  input  logic          rx_valid,
  input  logic          rx_first,
  input  logic [4:0]    rx_board,
  input  logic [33:0]   rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [FW-1:0] tx_frame,
  input  logic          tx_done,
  input  logic          tx_nack,
  input  logic [FW-1:0] rd_frame,
  input  logic [OW-1:0] rd_off,
  output logic [33:0]   rd_data
);
  import pktq_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  // free stack
  logic [FW-1:0] fs_top, fs_pdata;
  logic          fs_empty, fs_full, fs_push, fs_pop;

  frame_stack #(.W(FW), .DEPTH(NUM_FRAMES)) u_free (
    .clk(clk), .rst_n(rst_n_int), .push(fs_push), .pdata(fs_pdata),
    .pop(fs_pop), .top(fs_top), .empty(fs_empty), .full(fs_full));

  // local input queues
  logic [NUM_LOCAL-1:0] lq_push, lq_pop, lq_empty, lq_full;
  logic [FW-1:0]        lq_head [NUM_LOCAL];
  logic [FW-1:0]        lq_pdata;

  for (genvar g = 0; g < NUM_LOCAL; g++) begin : g_local
    frame_fifo #(.W(FW), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n_int), .push(lq_push[g]), .pdata(lq_pdata),
      .pop(lq_pop[g]), .head(lq_head[g]), .empty(lq_empty[g]), .full(lq_full[g]));
  end

  // transmit queue pair; role_q names the one acting as send queue
  logic [1:0]    sq_push, sq_pop, sq_empty, sq_full;
  logic [FW-1:0] sq_head [2];
  logic [FW-1:0] sq_pdata [2];
  logic          role_q, role_d;

  for (genvar g = 0; g < 2; g++) begin : g_send
    frame_fifo #(.W(FW), .DEPTH(NUM_FRAMES)) u_q (
      .clk(clk), .rst_n(rst_n_int), .push(sq_push[g]), .pdata(sq_pdata[g]),
      .pop(sq_pop[g]), .head(sq_head[g]), .empty(sq_empty[g]), .full(sq_full[g]));
  end

  // holding register and receive state
  logic          tmp_valid_q, tmp_valid_d;
  logic [FW-1:0] tmp_frame_q, tmp_frame_d;
  logic [11:0]   tmp_hdr_q, tmp_hdr_d;
  logic          rx_busy_q, rx_busy_d;
  logic [FW-1:0] rx_frame_q, rx_frame_d;
  logic [OW-1:0] rx_off_q, rx_off_d;
  logic [6:0]    rx_hdr_q, rx_hdr_d;

  // buffer
  logic             mem_we;
  logic [FW+OW-1:0] mem_waddr;
  logic [33:0]      mem_wdata;

  pkt_buffer #(.FW(FW), .OW(OW), .DW(WORD_W)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr({rd_frame, rd_off}), .rdata(rd_data));

  // decode
  cmd_e          op;
  logic [2:0]    cmd_dest, rx_dest;
  logic          dest_blocked, agent_ok, path_free, rdy;
  logic          cmd_fire, rx_fire, rx_last, rx_push, tx_acc;
  logic          cmd_lpush, cmd_rpush;
  logic [FW-1:0] cmd_push_frame, rx_frame_cur;
  logic [33:0]   hdr_sel;

  always_comb begin
    op        = cmd_e'(cmd_op);
    hdr_sel   = (op == CMD_CLOSE) ? {1'b0, tmp_hdr_q, 21'd0} : cmd_data;
    cmd_dest  = dest_of(hdr_sel, my_board, 1'b0);
    dest_blocked = (cmd_dest == DEST_REMOTE) ? sq_full[role_q] : lq_full[cmd_dest];
    agent_ok  = (cmd_agent < 3'(NUM_LOCAL));
    path_free = !rx_valid && !tx_done;
    unique case (op)
      CMD_SEND1:   rdy = !fs_empty && !dest_blocked;
      CMD_OPEN:    rdy = !fs_empty && !tmp_valid_q;
      CMD_PUT:     rdy = tmp_valid_q;
      CMD_CLOSE:   rdy = tmp_valid_q && !dest_blocked;
      CMD_TAKE:    rdy = agent_ok && !lq_empty[cmd_agent];
      CMD_RELEASE: rdy = !fs_full;
      default:     rdy = 1'b0;
    endcase
    cmd_ready = path_free && rdy;
    unique case (op)
      CMD_SEND1, CMD_OPEN: rsp_frame = fs_top;
      CMD_PUT, CMD_CLOSE:  rsp_frame = tmp_frame_q;
      CMD_TAKE:            rsp_frame = agent_ok ? lq_head[cmd_agent] : '0;
      default:             rsp_frame = cmd_frame;
    endcase
    cmd_fire       = cmd_valid && cmd_ready;
    cmd_push_frame = (op == CMD_CLOSE) ? tmp_frame_q : fs_top;
    cmd_lpush = cmd_fire && ((op == CMD_SEND1) || (op == CMD_CLOSE)) && (cmd_dest != DEST_REMOTE);
    cmd_rpush = cmd_fire && ((op == CMD_SEND1) || (op == CMD_CLOSE)) && (cmd_dest == DEST_REMOTE);

    // receive side
    rx_last      = !rx_data[CONT_BIT];
    rx_dest      = rx_first ? dest_of(rx_data, my_board, 1'b1)
                            : dest_of({1'b0, rx_hdr_q, 26'd0}, my_board, 1'b1);
    rx_frame_cur = rx_first ? fs_top : rx_frame_q;
    if (rx_first) rx_ready = !fs_empty && (!rx_last || !lq_full[rx_dest]);
    else          rx_ready = rx_busy_q && (!rx_last || !lq_full[rx_dest]);
    rx_fire = rx_valid && rx_ready;
    rx_push = rx_fire && rx_last;

    // transmit side
    tx_valid = !sq_empty[role_q];
    tx_frame = sq_head[role_q];
    tx_acc   = tx_done && tx_valid;
  end

  // datapath steering
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = {fs_top, {OW{1'b0}}};
    mem_wdata = cmd_data;
    if (rx_fire) begin
      mem_we    = 1'b1;
      mem_waddr = rx_first ? {fs_top, {OW{1'b0}}} : {rx_frame_q, rx_off_q};
      mem_wdata = rx_first ? {rx_data[33:26], rx_board, rx_data[20:0]} : rx_data;
    end else if (cmd_fire && ((op == CMD_SEND1) || (op == CMD_OPEN))) begin
      mem_we = 1'b1;
    end else if (cmd_fire && (op == CMD_PUT)) begin
      mem_we    = 1'b1;
      mem_waddr = {tmp_frame_q, cmd_off};
    end

    fs_pop   = (rx_fire && rx_first) || (cmd_fire && ((op == CMD_SEND1) || (op == CMD_OPEN)));
    fs_push  = (tx_acc && !tx_nack) || (cmd_fire && (op == CMD_RELEASE));
    fs_pdata = tx_acc ? tx_frame : cmd_frame;

    lq_pdata = rx_push ? rx_frame_cur : cmd_push_frame;
    for (int i = 0; i < NUM_LOCAL; i++) begin
      lq_push[i] = (rx_push && (rx_dest == 3'(i))) || (cmd_lpush && (cmd_dest == 3'(i)));
      lq_pop[i]  = cmd_fire && (op == CMD_TAKE) && (cmd_agent == 3'(i));
    end
    for (int i = 0; i < 2; i++) begin
      sq_push[i]  = (cmd_rpush && (role_q == i[0])) || (tx_acc && tx_nack && (role_q != i[0]));
      sq_pdata[i] = cmd_rpush ? cmd_push_frame : tx_frame;
      sq_pop[i]   = tx_acc && (role_q == i[0]);
    end
  end

  // next state
  always_comb begin
    role_d      = role_q ^ (sq_empty[role_q] && !sq_empty[!role_q]);
    tmp_valid_d = tmp_valid_q;
    tmp_frame_d = tmp_frame_q;
    tmp_hdr_d   = tmp_hdr_q;
    if (cmd_fire && (op == CMD_OPEN)) begin
      tmp_valid_d = 1'b1;
      tmp_frame_d = fs_top;
      tmp_hdr_d   = cmd_data[32:21];
    end else if (cmd_fire && (op == CMD_CLOSE)) begin
      tmp_valid_d = 1'b0;
    end
    rx_busy_d  = rx_busy_q;
    rx_frame_d = rx_frame_q;
    rx_off_d   = rx_off_q;
    rx_hdr_d   = rx_hdr_q;
    if (rx_fire) begin
      rx_busy_d = !rx_last;
      if (rx_first) begin
        rx_frame_d = fs_top;
        rx_off_d   = OW'(1);
        rx_hdr_d   = rx_data[32:26];
      end else begin
        rx_off_d = rx_off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      role_q      <= 1'b0;
      tmp_valid_q <= 1'b0;
      tmp_frame_q <= '0;
      tmp_hdr_q   <= '0;
      rx_busy_q   <= 1'b0;
      rx_frame_q  <= '0;
      rx_off_q    <= '0;
      rx_hdr_q    <= '0;
    end else begin
      role_q      <= role_d;
      tmp_valid_q <= tmp_valid_d;
      tmp_frame_q <= tmp_frame_d;
      tmp_hdr_q   <= tmp_hdr_d;
      rx_busy_q   <= rx_busy_d;
      rx_frame_q  <= rx_frame_d;
      rx_off_q    <= rx_off_d;
      rx_hdr_q    <= rx_hdr_d;
    end
  end
endmodule

// File: rtl/pktq_manager_chk.sv
module pktq_manager_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       cmd_ready,
  input logic [2:0] cmd_dest,
  input logic       rx_valid,
  input logic       rx_first,
  input logic       rx_ready,
  input logic       rx_last,
  input logic [2:0] rx_dest,
  input logic       tx_valid,
  input logic       tx_done,
  input logic       tx_nack,
  input logic       fs_empty,
  input logic [4:0] lq_empty,
  input logic [4:0] lq_full,
  input logic [1:0] sq_empty,
  input logic       role_q
);
  assert_no_grant_when_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first && fs_empty) |-> !rx_ready);

  assert_ack_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_valid && !tx_nack) |=> !fs_empty);

  assert_nack_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_valid && tx_nack) |=> !(sq_empty[0] && sq_empty[1]));

  assert_role_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_empty[role_q] && !sq_empty[!role_q]) |=> tx_valid);

  assert_full_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd1) && (cmd_dest < 3'd5) && lq_full[cmd_dest]) |-> !cmd_ready);

  assert_rx_delivered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_last) |=> !lq_empty[$past(rx_dest)]);
endmodule

bind pktq_manager pktq_manager_chk u_chk (
  .clk(clk), .rst_n(rst_n_int), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .cmd_dest(cmd_dest), .rx_valid(rx_valid),
  .rx_first(rx_first), .rx_ready(rx_ready), .rx_last(rx_last), .rx_dest(rx_dest),
  .tx_valid(tx_valid), .tx_done(tx_done), .tx_nack(tx_nack), .fs_empty(fs_empty),
  .lq_empty(lq_empty), .lq_full(lq_full), .sq_empty(sq_empty), .role_q(role_q));

// File: tb/test_pktq_manager.sv
module test_pktq_manager;
  localparam int NF = 8;
  localparam int FW = 3;
  localparam int OW = 4;

  logic clk, rst_n;
  logic [4:0] my_board;
  logic cmd_valid; logic [2:0] cmd_op, cmd_agent; logic [FW-1:0] cmd_frame;
  logic [OW-1:0] cmd_off; logic [33:0] cmd_data; logic cmd_ready; logic [FW-1:0] rsp_frame;
  logic rx_valid, rx_first; logic [4:0] rx_board; logic [33:0] rx_data; logic rx_ready;
  logic tx_valid; logic [FW-1:0] tx_frame; logic tx_done, tx_nack;
  logic [FW-1:0] rd_frame; logic [OW-1:0] rd_off; logic [33:0] rd_data;

  pktq_manager #(.NUM_FRAMES(NF), .WORDS(16), .QDEPTH(4)) i_pktq_manager (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [33:0] mk(input logic c, input logic [1:0] pe, input logic [4:0] op,
                                     input logic [4:0] brd, input logic [20:0] info);
    return {c, pe, op, brd, info};
  endfunction

  task automatic cmd(input logic [2:0] o, input logic [2:0] ag, input logic [FW-1:0] fr,
                     input logic [OW-1:0] off, input logic [33:0] d,
                     output logic ok, output logic [FW-1:0] rf);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = o; cmd_agent = ag; cmd_frame = fr; cmd_off = off; cmd_data = d;
    #1; ok = cmd_ready; rf = rsp_frame;
    @(posedge clk); #1 cmd_valid = 1'b0;
  endtask

  task automatic rxw(input logic first, input logic [4:0] brd, input logic [33:0] d, output logic ok);
    @(negedge clk);
    rx_valid = 1'b1; rx_first = first; rx_board = brd; rx_data = d;
    #1; ok = rx_ready;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic txack(input logic nack);
    @(negedge clk);
    tx_done = 1'b1; tx_nack = nack;
    @(posedge clk); #1 tx_done = 1'b0; tx_nack = 1'b0;
  endtask

  task automatic rdw(input logic [FW-1:0] f, input logic [OW-1:0] o, output logic [33:0] d);
    rd_frame = f; rd_off = o; #1 d = rd_data;
  endtask

  // {pe, opcode, board, expected destination: 0..3 PE, 4 memory, 5 remote}
  localparam logic [14:0] VEC [7] = '{
    {2'd0, 5'd0,  5'd3, 3'd0},
    {2'd1, 5'd0,  5'd3, 3'd1},
    {2'd2, 5'd0,  5'd3, 3'd2},
    {2'd3, 5'd0,  5'd3, 3'd3},
    {2'd1, 5'd7,  5'd3, 3'd4},
    {2'd2, 5'd0,  5'd9, 3'd5},
    {2'd0, 5'd31, 5'd3, 3'd4}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R12 watchdog act=hang exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ok; logic [FW-1:0] f, fa, fb, g; logic [33:0] d, h; logic [NF-1:0] seen; int n;
    rst_n = 1'b0; my_board = 5'd3;
    cmd_valid = 0; cmd_op = 0; cmd_agent = 0; cmd_frame = 0; cmd_off = 0; cmd_data = 0;
    rx_valid = 0; rx_first = 0; rx_board = 0; rx_data = 0; tx_done = 0; tx_nack = 0;
    rd_frame = 0; rd_off = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R13: reset state
    @(negedge clk); #1 chk(tx_valid == 1'b0, "R13 tx_valid after reset", tx_valid, 0);
    for (int a = 0; a < 5; a++) begin
      cmd(3'd5, 3'(a), 0, 0, 0, ok, f);
      chk(!ok, "R13 queue empty after reset", ok, 0);
    end

    // table walk: R2 R3 R4 R8
    for (int i = 0; i < 7; i++) begin
      h = mk(1'b0, VEC[i][14:13], VEC[i][12:8], VEC[i][7:3], 21'(i * 4097 + 5));
      cmd(3'd1, 0, 0, 0, h, ok, f);
      chk(ok, "R8 single send accepted", ok, 1);
      rdw(f, 0, d);
      chk(d == h, "R8 word at offset 0", d, h);
      if (VEC[i][2:0] == 3'd5) begin
        @(negedge clk); #1;
        chk(tx_valid && tx_frame == f, "R4 remote frame on tx", tx_frame, f);
        txack(1'b0);
      end else begin
        cmd(3'd5, VEC[i][2:0], 0, 0, 0, ok, g);
        chk(ok && g == f, "R3 frame in expected local queue", g, f);
        cmd(3'd6, 0, g, 0, 0, ok, g);
      end
    end

    // R5 R6: reject then role swap
    cmd(3'd1, 0, 0, 0, mk(0, 0, 0, 5'd12, 0), ok, fa);
    cmd(3'd1, 0, 0, 0, mk(0, 0, 0, 5'd12, 1), ok, fb);
    @(negedge clk); #1 chk(tx_frame == fa, "R4 first remote at head", tx_frame, fa);
    txack(1'b1);
    @(negedge clk); #1 chk(tx_valid && tx_frame == fb, "R5 nack removes head from send", tx_frame, fb);
    txack(1'b0);
    @(negedge clk); #1 chk(!tx_valid, "R6 send queue empty before swap", tx_valid, 0);
    @(negedge clk); #1 chk(tx_valid && tx_frame == fa, "R6 rejected frame offered after swap", tx_frame, fa);
    txack(1'b0);

    // R10 R12: drain the free stack
    seen = '0; n = 0;
    for (int i = 0; i < NF; i++) begin
      cmd(3'd1, 0, 0, 0, mk(0, 0, 0, 5'd20, 0), ok, f);
      if (ok && !seen[f]) n++;
      if (ok) seen[f] = 1'b1;
    end
    chk(n == NF, "R12 all frames distinct and allocatable", n, NF);
    cmd(3'd1, 0, 0, 0, mk(0, 0, 0, 5'd20, 0), ok, f);
    chk(!ok, "R10 single send with no free frame", ok, 0);
    cmd(3'd2, 0, 0, 0, mk(1, 0, 4, 5'd3, 0), ok, f);
    chk(!ok, "R10 open with no free frame", ok, 0);
    rxw(1'b1, 5'd9, mk(0, 0, 0, 5'd3, 0), ok);
    chk(!ok, "R10 receive header with no free frame", ok, 0);
    for (int i = 0; i < NF; i++) txack(1'b0);

    // R11: local queue full
    for (int i = 0; i < 4; i++) cmd(3'd1, 0, 0, 0, mk(0, 2'd1, 0, 5'd3, 0), ok, f);
    cmd(3'd1, 0, 0, 0, mk(0, 2'd1, 0, 5'd3, 0), ok, f);
    chk(!ok, "R11 push to full queue refused", ok, 0);
    for (int i = 0; i < 4; i++) begin
      cmd(3'd5, 3'd1, 0, 0, 0, ok, g);
      cmd(3'd6, 0, g, 0, 0, ok, g);
    end
    cmd(3'd5, 3'd1, 0, 0, 0, ok, g);
    chk(!ok, "R11 take on empty queue refused", ok, 0);

    // R9 R1: multi-word build to memory agent
    h = mk(1, 2'd2, 5'd6, 5'd3, 21'h1abcd);
    cmd(3'd2, 0, 0, 0, h, ok, fa);
    chk(ok, "R9 open accepted", ok, 1);
    cmd(3'd3, 0, 0, 4'd1, 34'h2_1234_5678, ok, f);
    cmd(3'd3, 0, 0, 4'd2, 34'h0_0bad_f00d, ok, f);
    cmd(3'd5, 3'd4, 0, 0, 0, ok, g);
    chk(!ok, "R9 nothing delivered before close", ok, 0);
    cmd(3'd4, 0, 0, 0, 0, ok, f);
    chk(ok && f == fa, "R9 close uses held frame", f, fa);
    cmd(3'd5, 3'd4, 0, 0, 0, ok, g);
    chk(ok && g == fa, "R9 packet in memory agent queue", g, fa);
    rdw(g, 4'd2, d);
    chk(d == 34'h0_0bad_f00d, "R9 put word stored", d, 34'h0_0bad_f00d);
    cmd(3'd6, 0, g, 0, 0, ok, g);

    // R7 R1: receive with header rewrite
    rxw(1'b1, 5'd9, mk(1, 2'd2, 0, 5'd3, 21'h777), ok);
    chk(ok, "R7 receive header accepted", ok, 1);
    cmd(3'd5, 3'd2, 0, 0, 0, ok, g);
    chk(!ok, "R1 not delivered before final word", ok, 0);
    rxw(1'b0, 5'd9, 34'h0_cafe_0001, ok);
    cmd(3'd5, 3'd2, 0, 0, 0, ok, g);
    chk(ok, "R7 delivered to processor 2", ok, 1);
    rdw(g, 0, d);
    chk(d == mk(1, 2'd2, 0, 5'd9, 21'h777), "R7 board field rewritten", d, mk(1, 2'd2, 0, 5'd9, 21'h777));
    rdw(g, 1, d);
    chk(d == 34'h0_cafe_0001, "R7 data word unchanged", d, 34'h0_cafe_0001);
    cmd(3'd6, 0, g, 0, 0, ok, g);

    // R12: final conservation sweep
    seen = '0; n = 0;
    for (int i = 0; i < NF + 1; i++) begin
      cmd(3'd1, 0, 0, 0, mk(0, 0, 0, 5'd21, 0), ok, f);
      if (ok && !seen[f]) n++;
      if (ok) seen[f] = 1'b1;
    end
    chk(n == NF, "R12 frames conserved at end", n, NF);
    for (int i = 0; i < NF; i++) txack(1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule